// File: doc/BRIEF.md
# Byte-Wide Serial Peripheral Controller with Register Bank

This block is an 8-bit serial peripheral controller that a processor drives through five byte-wide register slots selected by a small index. One configuration register switches the module on, picks master or slave operation, the idle clock level, the sampling phase, the bit order and whether the module drives its own slave-select pin. It also enables two separate interrupt groups. A divider register sets the serial clock rate in master mode, a status register reports three flags, and a data slot reaches a one-byte transmit buffer on write and a one-byte receive buffer on read.

In master mode, software writes a byte whenever the transmit-empty flag is set. The byte moves into the shifter as soon as the shifter is idle, and eight clock pulses exchange it with the remote device. The received byte lands in the receive buffer and sets the receive-full flag. In slave mode the same engine follows an external clock while the select input is low. A freeze input holds every flip-flop while it is high. A transfer that was frozen continues from the same point after release, and a reset applied during the freeze returns the block to its reset state.

Register accesses finish in one clock cycle and there is no back-pressure. A write that arrives while the transmit buffer is full is dropped. Software paces transmission with the transmit-empty flag and reception with the receive-full flag. Every register access is a plain strobe, so no valid/ready handshake is used.

Top module: `spi_regbank_ctrl`

## Requirements
- R1: After reset, the configuration slot reads 0x04 (only the phase bit set) and status reads 0x02. The interrupt output is low, the slave-select output is high and the serial clock output is low.
- R2: The register index map is: 0 = configuration, 1 = reserved, 2 = clock divider, 3 = status, 4 = data. The reserved slot reads 0 and ignores writes. Configuration bits from bit 7 down to bit 0 are: receive/fault interrupt enable, module enable, transmit interrupt enable, master select, clock polarity, clock phase, select-output enable, LSB-first. Status bit 0 is receive-full, bit 1 is transmit-empty and bit 2 is mode fault.
- R3: In master mode, a data write while transmit-empty is set loads the byte and clears the flag. The byte enters the shifter when the shifter is idle, which sets transmit-empty again. The byte is sent with eight clock pulses of half-period (divider+1) clock cycles. With phase 0, data is sampled on the leading edge and shifted on the trailing edge. With phase 1, data is shifted on the leading edge and sampled on the trailing edge. The serial clock idles at the polarity bit.
- R4: With LSB-first set, both the sent bits and the received bits run from bit 0 to bit 7. Otherwise they run from bit 7 to bit 0.
- R5: A data write while transmit-empty is clear is ignored.
- R6: When a byte completes, it is copied to the receive buffer and receive-full is set. Receive-full clears only after a status read that sees the flag set, followed by a data read. A data read on its own leaves the flag set.
- R7: The interrupt output is high exactly when (receive/fault enable AND (receive-full OR mode fault)) OR (transmit enable AND transmit-empty).
- R8: While the enable bit is 0, any transfer is aborted, both buffers are cleared, receive-full is 0, transmit-empty is 1 and data writes are ignored.
- R9: In master mode with select-output disabled, a low select input sets the mode-fault flag, clears the master bit and aborts the transfer. The flag clears after a status read that sees it set, followed by a configuration write.
- R10: While freeze is high, no register, flag, shifter or pin state changes and register writes have no effect. After release the transfer finishes with the correct data. A reset during the freeze restores the R1 state.
- R11: In slave mode, while the select input is low, the block samples the data input and shifts its buffered byte out on the slave data output, on the edges of the external clock chosen by the phase bit. A falling select loads the transmit buffer.
- R12: In master mode with select-output enabled, the select output is low for the whole transfer and high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| freeze_i | input | 1 | Holds all state while high |
| reg_sel_i | input | 3 | Register index |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 8 | Write data |
| rd_en_i | input | 1 | Read strobe (flag-clearing side effects) |
| rd_data_o | output | 8 | Read data of the selected slot |
| irq_o | output | 1 | Interrupt request |
| sck_o | output | 1 | Serial clock driven in master mode |
| sck_i | input | 1 | Serial clock received in slave mode |
| mosi_o | output | 1 | Master data out |
| mosi_i | input | 1 | Slave data in |
| miso_o | output | 1 | Slave data out |
| miso_i | input | 1 | Master data in |
| ss_no | output | 1 | Slave-select output, active low |
| ss_ni | input | 1 | Slave-select input, active low |

## Verification
The assertions check on every cycle the properties that hold cycle by cycle. These are: flags forced by a cleared enable bit, state frozen under freeze, the master bit dropping together with the mode-fault flag, the select output falling only after a pending byte in master mode, a silent interrupt line when both enables are clear, and a completed byte following an active shift. Whole-byte behaviour can only be shown by the directed scenarios, which use a bench-side remote device. That behaviour includes the bit order and the sampling edges in all four clock modes, the clock half-period, the two-step flag clearing, dropped writes, and a frozen transfer that ends with the right data.

// File: rtl/spi_pkg.sv
package spi_pkg;

  typedef enum logic [2:0] {
    REG_CFG  = 3'd0,
    REG_RSV  = 3'd1,
    REG_BAUD = 3'd2,
    REG_STAT = 3'd3,
    REG_DATA = 3'd4
  } reg_idx_e;

  // configuration bit positions
  localparam int unsigned C_RXIE = 7;
  localparam int unsigned C_EN   = 6;
  localparam int unsigned C_TXIE = 5;
  localparam int unsigned C_MSTR = 4;
  localparam int unsigned C_CPOL = 3;
  localparam int unsigned C_CPHA = 2;
  localparam int unsigned C_SSOE = 1;
  localparam int unsigned C_LSBF = 0;

  // status bit positions
  localparam int unsigned S_RXF  = 0;
  localparam int unsigned S_TXE  = 1;
  localparam int unsigned S_MODF = 2;

  localparam logic [7:0] CFG_RST = 8'h04;

endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int unsigned       W       = 3,
  parameter int unsigned       STAGES  = 2,
  parameter logic [W-1:0]      RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         hold_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      stg_q[g] <= RST_VAL;
      else if (!hold_i) stg_q[g] <= (g == 0) ? d_i : stg_q[(g == 0) ? 0 : g-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/spi_baud_gen.sv
module spi_baud_gen #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hold_i,
  input  logic          run_i,
  input  logic [CW-1:0] div_i,
  output logic          tick_o
);
  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!hold_i) cnt_q <= (run_i && !tick_o) ? cnt_q + 1'b1 : '0;
  end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hold_i,
  input  logic          en_i,
  input  logic          start_i,
  input  logic          step_i,
  input  logic          lsb_first_i,
  input  logic          cpha_i,
  input  logic [DW-1:0] load_i,
  input  logic          din_i,
  output logic          dout_o,
  output logic          sck_ph_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] rx_o
);
  localparam int unsigned EDGES = 2 * DW;
  localparam int unsigned EW    = $clog2(EDGES + 1);

  logic [DW-1:0] tx_q, rx_q;
  logic [EW-1:0] edge_q, edge_nx;
  logic          ph_q, busy_q, done_q;
  logic          lead, do_smp, do_shf;

  assign edge_nx = edge_q + 1'b1;
  assign lead    = edge_nx[0];
  // phase 0: sample leading, shift trailing; phase 1: shift leading (not the first), sample trailing
  assign do_smp  = cpha_i ? !lead : lead;
  assign do_shf  = cpha_i ? (lead && (edge_q != '0)) : !lead;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q   <= '0;
      rx_q   <= '0;
      edge_q <= '0;
      ph_q   <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (!hold_i) begin
      done_q <= 1'b0;
      if (!en_i) begin
        busy_q <= 1'b0;
        edge_q <= '0;
        ph_q   <= 1'b0;
      end else if (!busy_q && start_i) begin
        busy_q <= 1'b1;
        tx_q   <= load_i;
        rx_q   <= '0;
        edge_q <= '0;
        ph_q   <= 1'b0;
      end else if (busy_q && step_i) begin
        ph_q   <= !ph_q;
        edge_q <= edge_nx;
        if (do_smp) rx_q <= lsb_first_i ? {din_i, rx_q[DW-1:1]} : {rx_q[DW-2:0], din_i};
        if (do_shf) tx_q <= lsb_first_i ? {1'b0, tx_q[DW-1:1]} : {tx_q[DW-2:0], 1'b0};
        if (edge_nx == EW'(EDGES)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign dout_o   = lsb_first_i ? tx_q[0] : tx_q[DW-1];
  assign sck_ph_o = ph_q;
  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign rx_o     = rx_q;
endmodule

// File: rtl/spi_regbank_ctrl.sv
module spi_regbank_ctrl
  import spi_pkg::*;
#(
  parameter int unsigned DW          = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          freeze_i,
  input  logic [2:0]    reg_sel_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_en_i,
  output logic [DW-1:0] rd_data_o,
  output logic          irq_o,
  output logic          sck_o,
  input  logic          sck_i,
  output logic          mosi_o,
  input  logic          mosi_i,
  output logic          miso_o,
  input  logic          miso_i,
  output logic          ss_no,
  input  logic          ss_ni
);
  localparam int unsigned SW = 3;
  localparam logic [SW-1:0] SYNC_RST = 3'b010; // {mosi, ss, sck}

  logic [DW-1:0] cfg_q, baud_q, txbuf_q, rxbuf_q;
  logic          tx_empty_q, rx_full_q, modf_q, rx_arm_q, modf_arm_q;
  logic          p_sck_q, p_ss_q;
  logic [SW-1:0] sync_q;
  logic          s_sck, s_ss, s_mosi;
  logic          wr, rd, mstr, spe;
  logic          modf_evt, eng_en, eng_start, eng_step, baud_tick;
  logic          eng_busy, eng_done, eng_dout, eng_ph;
  logic [DW-1:0] eng_rx, eng_load;

  assign wr   = wr_en_i && !freeze_i;
  assign rd   = rd_en_i && !freeze_i;
  assign spe  = cfg_q[C_EN];
  assign mstr = cfg_q[C_MSTR];

  spi_in_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i, .rst_ni, .hold_i(freeze_i),
    .d_i({mosi_i, ss_ni, sck_i}), .q_o(sync_q)
  );
  assign {s_mosi, s_ss, s_sck} = sync_q;

  assign modf_evt  = spe && mstr && !cfg_q[C_SSOE] && !s_ss;
  assign eng_en    = spe && !modf_evt && (mstr || !s_ss);
  assign eng_start = eng_en && (mstr ? !tx_empty_q : (p_ss_q && !s_ss));
  assign eng_load  = (!mstr && tx_empty_q) ? '0 : txbuf_q;
  assign eng_step  = mstr ? baud_tick : ((s_sck ^ p_sck_q) && !s_ss);

  spi_baud_gen #(.CW(DW)) u_baud (
    .clk_i, .rst_ni, .hold_i(freeze_i),
    .run_i(eng_busy && mstr && spe), .div_i(baud_q), .tick_o(baud_tick)
  );

  spi_shift_engine #(.DW(DW)) u_eng (
    .clk_i, .rst_ni, .hold_i(freeze_i),
    .en_i(eng_en), .start_i(eng_start), .step_i(eng_step),
    .lsb_first_i(cfg_q[C_LSBF]), .cpha_i(cfg_q[C_CPHA]),
    .load_i(eng_load), .din_i(mstr ? miso_i : s_mosi),
    .dout_o(eng_dout), .sck_ph_o(eng_ph), .busy_o(eng_busy),
    .done_o(eng_done), .rx_o(eng_rx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q      <= DW'(CFG_RST);
      baud_q     <= '0;
      txbuf_q    <= '0;
      rxbuf_q    <= '0;
      tx_empty_q <= 1'b1;
      rx_full_q  <= 1'b0;
      modf_q     <= 1'b0;
      rx_arm_q   <= 1'b0;
      modf_arm_q <= 1'b0;
      p_sck_q    <= 1'b0;
      p_ss_q     <= 1'b1;
    end else if (!freeze_i) begin
      p_sck_q <= s_sck;
      p_ss_q  <= s_ss;
      if (wr && reg_sel_i == REG_CFG)  cfg_q  <= wr_data_i;
      if (wr && reg_sel_i == REG_BAUD) baud_q <= wr_data_i;
      if (modf_evt) cfg_q[C_MSTR] <= 1'b0;

      if (!spe) begin
        txbuf_q    <= '0;
        rxbuf_q    <= '0;
        tx_empty_q <= 1'b1;
        rx_full_q  <= 1'b0;
        rx_arm_q   <= 1'b0;
      end else begin
        if (eng_start && !eng_busy) tx_empty_q <= 1'b1;
        if (wr && reg_sel_i == REG_DATA && tx_empty_q) begin
          txbuf_q    <= wr_data_i;
          tx_empty_q <= 1'b0;
        end
        if (rd && reg_sel_i == REG_STAT && rx_full_q) rx_arm_q <= 1'b1;
        if (rd && reg_sel_i == REG_DATA && rx_arm_q) begin
          rx_full_q <= 1'b0;
          rx_arm_q  <= 1'b0;
        end
        if (eng_done) begin
          rxbuf_q   <= eng_rx;
          rx_full_q <= 1'b1;
        end
      end

      if (rd && reg_sel_i == REG_STAT && modf_q) modf_arm_q <= 1'b1;
      if (wr && reg_sel_i == REG_CFG && modf_arm_q) begin
        modf_q     <= 1'b0;
        modf_arm_q <= 1'b0;
      end
      if (modf_evt) modf_q <= 1'b1;
    end
  end

  always_comb begin
    rd_data_o = '0;
    case (reg_sel_i)
      REG_CFG:  rd_data_o = cfg_q;
      REG_BAUD: rd_data_o = baud_q;
      REG_STAT: begin
        rd_data_o[S_RXF]  = rx_full_q;
        rd_data_o[S_TXE]  = tx_empty_q;
        rd_data_o[S_MODF] = modf_q;
      end
      REG_DATA: rd_data_o = rxbuf_q;
      default:  rd_data_o = '0;
    endcase
  end

  assign irq_o  = (cfg_q[C_RXIE] && (rx_full_q || modf_q)) || (cfg_q[C_TXIE] && tx_empty_q);
  assign sck_o  = cfg_q[C_CPOL] ^ (mstr && eng_ph);
  assign mosi_o = mstr && eng_dout;
  assign miso_o = !mstr && eng_dout;
  assign ss_no  = !(mstr && cfg_q[C_SSOE] && eng_busy);
endmodule

// File: rtl/spi_regbank_ctrl_chk.sv
module spi_regbank_ctrl_chk
  import spi_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          freeze,
  input logic [DW-1:0] cfg,
  input logic          tx_empty,
  input logic          rx_full,
  input logic          modf,
  input logic          busy,
  input logic          done,
  input logic          sck,
  input logic          ss_n,
  input logic          irq
);
  assert_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg[C_EN] && !freeze) |=> (tx_empty && !rx_full && !busy))
    else $error("flags not forced while disabled");

  assert_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> ($stable(cfg) && $stable(tx_empty) && $stable(rx_full) &&
                $stable(modf) && $stable(busy) && $stable(sck)))
    else $error("state moved during freeze");

  assert_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(modf) |-> !cfg[C_MSTR])
    else $error("master bit kept after fault");

  assert_select_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ss_n) |-> $past(!tx_empty && cfg[C_MSTR]))
    else $error("select fell without a pending byte");

  assert_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg[C_RXIE] && !cfg[C_TXIE]) |-> !irq)
    else $error("interrupt with both enables clear");

  assert_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)))
    else $error("completion without an active shift");
endmodule

bind spi_regbank_ctrl spi_regbank_ctrl_chk #(.DW(DW)) u_chk (
  .clk(clk_i), .rst_n(rst_ni), .freeze(freeze_i), .cfg(cfg_q),
  .tx_empty(tx_empty_q), .rx_full(rx_full_q), .modf(modf_q),
  .busy(eng_busy), .done(eng_done), .sck(sck_o), .ss_n(ss_no), .irq(irq_o)
);

// File: tb/spi_regbank_ctrl_tb.sv
module spi_regbank_ctrl_tb;
  import spi_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       freeze = 1'b0;
  logic [2:0] sel = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdat = '0;
  logic [7:0] rdat;
  logic       irq, sck_o, mosi_o, miso_o, miso_i, ss_no;
  logic       sck_i = 1'b0, mosi_i = 1'b0, ss_ni = 1'b1;
  int         n_chk = 0, n_err = 0;

  // bench-side remote device for master tests
  bit         m_on = 1'b0;
  logic       m_cpol = 1'b0, m_cpha = 1'b0, m_lsb = 1'b0;
  int         m_k = 0, m_lead = 0, m_edges = 0;
  logic [7:0] m_got = '0, m_pat = '0;
  realtime    m_t1 = 0, m_t2 = 0;

  always #(CLK_PERIOD/2) clk = !clk;

  spi_regbank_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .freeze_i(freeze), .reg_sel_i(sel),
    .wr_en_i(wr), .wr_data_i(wdat), .rd_en_i(rd), .rd_data_o(rdat),
    .irq_o(irq), .sck_o(sck_o), .sck_i(sck_i), .mosi_o(mosi_o), .mosi_i(mosi_i),
    .miso_o(miso_o), .miso_i(miso_i), .ss_no(ss_no), .ss_ni(ss_ni)
  );

  assign miso_i = (m_k < 8) ? m_pat[m_lsb ? m_k : 7 - m_k] : 1'b0;

  always @(sck_o) begin
    if (m_on) begin
      int idx;
      idx = m_lsb ? m_k : 7 - m_k;
      m_edges++;
      if (m_edges == 1) m_t1 = $realtime;
      if (m_edges == 2) m_t2 = $realtime;
      if (sck_o != m_cpol) begin
        m_lead++;
        if (!m_cpha) begin if (m_k < 8) m_got[idx] = mosi_o; end
        else if (m_lead > 1) m_k++;
      end else begin
        if (!m_cpha) m_k++;
        else if (m_k < 8) m_got[idx] = mosi_o;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk); sel = s; wdat = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] s, output logic [7:0] d);
    @(negedge clk); sel = s; rd = 1'b1; #1 d = rdat;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic peek(input logic [2:0] s, output logic [7:0] d);
    @(negedge clk); sel = s; #1 d = rdat;
  endtask

  task automatic wait_rxf();
    logic [7:0] r;
    int w = 0;
    do begin peek(REG_STAT, r); w++; end while (!r[S_RXF] && w < 5000);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; freeze = 1'b0; wr = 1'b0; rd = 1'b0;
    ss_ni = 1'b1; sck_i = 1'b0; mosi_i = 1'b0; m_on = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] r;
    peek(REG_CFG, r);  check("R1 cfg reset", r, 8'h04);
    peek(REG_STAT, r); check("R1 status reset", r, 8'h02);
    check("R1 irq reset", irq, 0);
    check("R1 ss reset", ss_no, 1);
    check("R1 sck reset", sck_o, 0);
    bus_wr(REG_RSV, 8'hFF);
    peek(REG_RSV, r);  check("R2 reserved slot", r, 0);
  endtask

  task automatic t_master(input string req, input logic cpol, input logic cpha,
                          input logic lsb, input logic [7:0] div,
                          input logic [7:0] txb, input logic [7:0] pat);
    logic [7:0] r;
    bus_wr(REG_BAUD, div);
    bus_wr(REG_CFG, {1'b0, 1'b1, 1'b0, 1'b1, cpol, cpha, 1'b1, lsb});
    m_cpol = cpol; m_cpha = cpha; m_lsb = lsb; m_pat = pat;
    m_k = 0; m_lead = 0; m_edges = 0; m_got = '0; m_on = 1'b1;
    check({req, " R3 sck idle"}, sck_o, cpol);
    bus_wr(REG_DATA, txb);
    @(negedge clk);
    check({req, " R12 select low"}, ss_no, 0);
    peek(REG_STAT, r); check({req, " R3 tx empty again"}, r[S_TXE], 1);
    wait_rxf();
    m_on = 1'b0;
    check({req, " R3 R4 sent bits"}, m_got, txb);
    check({req, " R3 half period"}, int'((m_t2 - m_t1) / CLK_PERIOD), div + 1);
    check({req, " R12 select high"}, ss_no, 1);
    bus_rd(REG_STAT, r);
    bus_rd(REG_DATA, r); check({req, " R3 R4 received"}, r, pat);
    peek(REG_STAT, r);   check({req, " R6 rx cleared"}, r[S_RXF], 0);
  endtask

  task automatic t_irq();
    logic [7:0] r;
    bus_wr(REG_CFG, 8'h60); @(negedge clk);
    check("R7 tx irq", irq, 1);
    bus_wr(REG_CFG, 8'h40); @(negedge clk);
    check("R7 no enables", irq, 0);
    bus_wr(REG_BAUD, 8'd1);
    bus_wr(REG_CFG, 8'hD2); @(negedge clk);
    check("R7 rx enable only", irq, 0);
    bus_wr(REG_DATA, 8'h11);
    wait_rxf();
    check("R7 rx irq", irq, 1);
    bus_rd(REG_DATA, r);
    peek(REG_STAT, r); check("R6 data read alone", r[S_RXF], 1);
    bus_rd(REG_STAT, r);
    bus_rd(REG_DATA, r);
    peek(REG_STAT, r); check("R6 two step clear", r[S_RXF], 0);
    check("R7 irq drops", irq, 0);
  endtask

  task automatic t_disable();
    logic [7:0] r;
    bus_wr(REG_BAUD, 8'd20);
    bus_wr(REG_CFG, 8'h52);
    bus_wr(REG_DATA, 8'hF0);
    wait_rxf();
    bus_wr(REG_DATA, 8'hFF);
    repeat (60) @(negedge clk);
    bus_wr(REG_CFG, 8'h12);
    peek(REG_STAT, r); check("R8 flags forced", r, 8'h02);
    check("R8 sck idle", sck_o, 0);
    check("R8 select released", ss_no, 1);
    peek(REG_DATA, r); check("R8 rx buffer cleared", r, 0);
    bus_wr(REG_DATA, 8'h77);
    peek(REG_STAT, r); check("R8 write ignored", r[S_TXE], 1);
  endtask

  task automatic t_modf();
    logic [7:0] r;
    bus_wr(REG_BAUD, 8'd10);
    bus_wr(REG_CFG, 8'hD0);
    peek(REG_STAT, r); check("R9 no fault", r[S_MODF], 0);
    bus_wr(REG_DATA, 8'hC3);
    repeat (30) @(negedge clk);
    ss_ni = 1'b0;
    repeat (6) @(negedge clk);
    peek(REG_STAT, r); check("R9 fault flag", r[S_MODF], 1);
    peek(REG_CFG, r);  check("R9 master cleared", r[C_MSTR], 0);
    check("R9 sck idle", sck_o, 0);
    check("R7 fault irq", irq, 1);
    repeat (300) @(negedge clk);
    peek(REG_STAT, r); check("R9 transfer aborted", r[S_RXF], 0);
    ss_ni = 1'b1;
    repeat (4) @(negedge clk);
    bus_rd(REG_STAT, r);
    bus_wr(REG_CFG, 8'h40);
    peek(REG_STAT, r); check("R9 fault cleared", r[S_MODF], 0);
  endtask

  task automatic t_freeze();
    logic [7:0] r, st;
    logic s;
    bus_wr(REG_BAUD, 8'd4);
    bus_wr(REG_CFG, 8'h52);
    m_cpol = 0; m_cpha = 0; m_lsb = 0; m_pat = 8'h69;
    m_k = 0; m_lead = 0; m_edges = 0; m_got = '0; m_on = 1'b1;
    bus_wr(REG_DATA, 8'h96);
    repeat (27) @(negedge clk);
    freeze = 1'b1;
    peek(REG_STAT, st); s = sck_o;
    repeat (40) @(negedge clk);
    check("R10 sck held", sck_o, s);
    check("R10 select held", ss_no, 0);
    bus_wr(REG_CFG, 8'h00);
    peek(REG_CFG, r);  check("R10 write ignored", r, 8'h52);
    peek(REG_STAT, r); check("R10 status held", r, st);
    freeze = 1'b0;
    wait_rxf();
    m_on = 1'b0;
    check("R10 resumed send", m_got, 8'h96);
    bus_rd(REG_STAT, r);
    bus_rd(REG_DATA, r); check("R10 resumed receive", r, 8'h69);
    bus_wr(REG_DATA, 8'h55);
    repeat (10) @(negedge clk);
    freeze = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    freeze = 1'b0;
    peek(REG_CFG, r);  check("R10 reset in freeze cfg", r, 8'h04);
    peek(REG_STAT, r); check("R10 reset in freeze status", r, 8'h02);
  endtask

  task automatic t_slave();
    logic [7:0] r, got;
    logic [7:0] sb = 8'h3C;
    bus_wr(REG_CFG, 8'h40);
    bus_wr(REG_DATA, 8'hA5);
    bus_wr(REG_DATA, 8'h5A);
    peek(REG_STAT, r); check("R5 buffer full", r[S_TXE], 0);
    ss_ni = 1'b0;
    repeat (10) @(negedge clk);
    peek(REG_STAT, r); check("R11 buffer loaded", r[S_TXE], 1);
    got = '0;
    for (int i = 0; i < 8; i++) begin
      mosi_i = sb[7-i];
      repeat (8) @(negedge clk);
      got[7-i] = miso_o;
      sck_i = 1'b1;
      repeat (8) @(negedge clk);
      sck_i = 1'b0;
    end
    repeat (8) @(negedge clk);
    ss_ni = 1'b1;
    check("R11 R5 slave sent first byte", got, 8'hA5);
    peek(REG_STAT, r); check("R11 rx full", r[S_RXF], 1);
    bus_rd(REG_STAT, r);
    bus_rd(REG_DATA, r); check("R11 slave received", r, sb);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    do_reset(); t_reset();
    do_reset(); t_irq();
    do_reset(); t_master("mode0", 1'b0, 1'b0, 1'b0, 8'd1, 8'hA5, 8'h3C);
    do_reset(); t_master("mode1", 1'b0, 1'b1, 1'b0, 8'd2, 8'h81, 8'h7E);
    do_reset(); t_master("mode2", 1'b1, 1'b0, 1'b0, 8'd0, 8'hC9, 8'h12);
    do_reset(); t_master("mode3", 1'b1, 1'b1, 1'b0, 8'd3, 8'h2B, 8'hE4);
    do_reset(); t_master("lsb0", 1'b0, 1'b0, 1'b1, 8'd1, 8'h01, 8'h80);
    do_reset(); t_master("lsb3", 1'b1, 1'b1, 1'b1, 8'd2, 8'hD4, 8'h35);
    do_reset(); t_disable();
    do_reset(); t_modf();
    do_reset(); t_freeze();
    do_reset(); t_slave();
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule